// File: doc/BRIEF.md
# SPI Flash Command Shifter

This block runs one short serial-flash transaction at a time on a single data line. Software fills six program bytes and a bit count through a small byte-wide register port, then writes a command code. The engine pulls chip select low and shifts the program bytes out most significant bit first. Every bit the flash returns is captured into a bank of readback bytes. The command word keeps its code while the transfer runs and reads zero once the transfer is done, so software polls it for completion.

The block has two fixed helpers next to the generic transfer. A status read sends a built-in opcode and keeps the one byte that comes back. A status write sends a built-in opcode followed by the top program byte. The serial clock idles low (mode 0) and runs at a fixed fraction of the system clock, set by a parameter.

Top module: `spi_cmd_shifter`

## Requirements
- R1: After reset, chip select is high, the serial clock is low and every register reads zero. A read strobe returns data one clock later. The register word map is: command at 0x00, bit count at 0x04, status byte at 0x08, program byte i at 0x10+4i (i = 0..5), and readback byte i at 0x40+4i (i = 0..5). An access whose two low address bits are not zero is ignored.
- R2: Writing code 0x04 to the command word starts a generic transfer of `count` bits. The bits go out MSB first: program byte 5 first, then bytes 4 down to 0, then zeros for bits 49 to 56.
- R3: A count above 56 is cut to 56 bits. A count of zero completes without lowering chip select and leaves every readback byte at zero.
- R4: The serial clock stays low while chip select is high. Data out changes only while the clock is low. The first rising edge comes CLK_DIV clocks after chip select falls, and each half period lasts CLK_DIV clocks.
- R5: Chip select rises 2*CLK_DIV clocks (one serial period) after the last falling clock edge.
- R6: At the end of a generic transfer, the received bits are packed so that the last byte received sits in readback byte 0 and earlier bytes sit at higher indices. Bits that were not received read zero. The readback bank keeps its old value during a transfer and is not touched by the status commands.
- R7: The command word reads back the running code during a transfer and reads zero after it is done.
- R8: Code 0x02 runs a 16-bit status read whatever the count is: opcode 0x05 and then eight zero bits go out, and the second byte received lands in the status byte.
- R9: Code 0x20 runs a 16-bit status write: opcode 0x01 goes out, then program byte 5.
- R10: A command write while the command word is non-zero is ignored.
- R11: The count and program bytes are sampled when the command is accepted. Writing them during a transfer does not change that transfer.
- R12: A command code other than 0x04, 0x02 or 0x20 is ignored: no transfer starts and the command word stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one clock after the strobe |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench targets four corner cases:
- Saturation at 56 bits: a design that passes the count through unchecked shifts 80 clocks, and the scoreboard sees too many bits.
- A count of zero: a design that starts anyway produces a transaction nobody expected.
- A count that is not a whole number of bytes: here a design that packs received bits by byte slot instead of by arrival puts the wrong nibble into readback byte 1.
- A command written mid-transfer: a design that accepts it while busy issues a second transfer.

The bench also rewrites the count and a program byte mid-transfer. A design that reads the registers live instead of sampling them at launch sends the wrong bits.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam logic [7:0] OPC_PROG = 8'h04;
  localparam logic [7:0] OPC_STRD = 8'h02;
  localparam logic [7:0] OPC_STWR = 8'h20;

  localparam int W_CMD  = 0;
  localparam int W_CNT  = 1;
  localparam int W_STS  = 2;
  localparam int W_PRG0 = 4;
  localparam int W_RB0  = 16;

  typedef enum logic [1:0] {XK_PROG, XK_STRD, XK_STWR} xfer_kind_e;
endpackage

// File: rtl/spi_cmd_sclk_gen.sv
module spi_cmd_sclk_gen #(
  parameter int CLK_DIV = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  generate
    if (CLK_DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      logic [CW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst || !run) div_q <= '0;
        else if (div_q == CW'(CLK_DIV - 1)) div_q <= '0;
        else div_q <= div_q + CW'(1);
      end
      assign tick = run && (div_q == CW'(CLK_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int MAX_BITS = 56,
  parameter int RX_W     = 48,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [CNT_W-1:0]    go_bits,
  input  logic [MAX_BITS-1:0] go_tx,
  input  logic                tick,
  input  logic                miso,
  output logic                run,
  output logic                cs_n,
  output logic                sck,
  output logic                mosi,
  output logic                done,
  output logic [RX_W-1:0]     rx
);
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} st_e;

  st_e                 state;
  logic [MAX_BITS-1:0] tx_q;
  logic [RX_W-1:0]     rx_q;
  logic [CNT_W-1:0]    bit_q;
  logic [CNT_W-1:0]    len_q;
  logic                tail_q;

  always_comb begin
    run  = (state != ST_IDLE);
    mosi = tx_q[MAX_BITS-1];
    rx   = rx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      len_q  <= '0;
      tail_q <= 1'b0;
      cs_n   <= 1'b1;
      sck    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (go) begin
            rx_q <= '0;
            if (go_bits == '0) begin
              done <= 1'b1;
            end else begin
              state <= ST_SHIFT;
              cs_n  <= 1'b0;
              tx_q  <= go_tx;
              bit_q <= '0;
              len_q <= go_bits;
            end
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sck) begin
              sck  <= 1'b1;
              rx_q <= {rx_q[RX_W-2:0], miso};
            end else begin
              sck <= 1'b0;
              if (bit_q + CNT_W'(1) == len_q) begin
                state  <= ST_TAIL;
                tail_q <= 1'b0;
              end else begin
                tx_q  <= tx_q << 1;
                bit_q <= bit_q + CNT_W'(1);
              end
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            if (tail_q) begin
              state <= ST_IDLE;
              cs_n  <= 1'b1;
              tx_q  <= '0;
              done  <= 1'b1;
            end else begin
              tail_q <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          NPRG     = 6,
  parameter int          RX_W     = 48,
  parameter int          MAX_BITS = 56,
  parameter int          CNT_W    = 6,
  parameter logic [7:0]  STRD_OP  = 8'h05,
  parameter logic [7:0]  STWR_OP  = 8'h01
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  output logic                go,
  output logic [CNT_W-1:0]    go_bits,
  output logic [MAX_BITS-1:0] go_tx,
  input  logic                done,
  input  logic [RX_W-1:0]     done_rx
);
  localparam int WI_W = ADDR_W - 2;
  localparam int NRB  = RX_W / 8;

  logic [WI_W-1:0]     widx;
  logic                aligned;
  logic [7:0]          cmd_q, cnt_q, sts_q;
  logic [7:0]          prg_q [NPRG];
  logic [RX_W-1:0]     rb_q;
  xfer_kind_e          kind_q;
  logic [MAX_BITS-1:0] tx_prog, tx_strd, tx_stwr;
  logic [CNT_W-1:0]    prog_bits;
  logic [7:0]          rd_mux;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  always_comb begin
    tx_prog = '0;
    for (int i = 0; i < NPRG; i++)
      tx_prog[MAX_BITS - 8*(NPRG - i) +: 8] = prg_q[i];
    tx_strd = '0;
    tx_strd[MAX_BITS-1 -: 8] = STRD_OP;
    tx_stwr = '0;
    tx_stwr[MAX_BITS-1 -: 8] = STWR_OP;
    tx_stwr[MAX_BITS-9 -: 8] = prg_q[NPRG-1];
    prog_bits = (cnt_q > 8'(MAX_BITS)) ? CNT_W'(MAX_BITS) : CNT_W'(cnt_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      cnt_q   <= '0;
      sts_q   <= '0;
      rb_q    <= '0;
      kind_q  <= XK_PROG;
      go      <= 1'b0;
      go_bits <= '0;
      go_tx   <= '0;
      for (int i = 0; i < NPRG; i++) prg_q[i] <= '0;
    end else begin
      go <= 1'b0;
      if (done) begin
        cmd_q <= '0;
        if (kind_q == XK_PROG) rb_q <= done_rx;
        else if (kind_q == XK_STRD) sts_q <= done_rx[7:0];
      end
      if (bus_wr && aligned) begin
        if (widx == WI_W'(W_CNT)) cnt_q <= bus_wdata;
        if (widx == WI_W'(W_CMD) && cmd_q == '0) begin
          if (bus_wdata == OPC_PROG) begin
            kind_q  <= XK_PROG;
            go_bits <= prog_bits;
            go_tx   <= tx_prog;
            cmd_q   <= bus_wdata;
            go      <= 1'b1;
          end else if (bus_wdata == OPC_STRD) begin
            kind_q  <= XK_STRD;
            go_bits <= CNT_W'(16);
            go_tx   <= tx_strd;
            cmd_q   <= bus_wdata;
            go      <= 1'b1;
          end else if (bus_wdata == OPC_STWR) begin
            kind_q  <= XK_STWR;
            go_bits <= CNT_W'(16);
            go_tx   <= tx_stwr;
            cmd_q   <= bus_wdata;
            go      <= 1'b1;
          end
        end
        for (int i = 0; i < NPRG; i++)
          if (widx == WI_W'(W_PRG0 + i)) prg_q[i] <= bus_wdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (widx == WI_W'(W_CMD)) rd_mux = cmd_q;
      if (widx == WI_W'(W_CNT)) rd_mux = cnt_q;
      if (widx == WI_W'(W_STS)) rd_mux = sts_q;
      for (int i = 0; i < NPRG; i++)
        if (widx == WI_W'(W_PRG0 + i)) rd_mux = prg_q[i];
      for (int i = 0; i < NRB; i++)
        if (widx == WI_W'(W_RB0 + i)) rd_mux = rb_q[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int         ADDR_W    = 8,
  parameter int         NPRG      = 6,
  parameter int         MAX_BYTES = 7,
  parameter int         CLK_DIV   = 3,
  parameter logic [7:0] STRD_OP   = 8'h05,
  parameter logic [7:0] STWR_OP   = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int MAX_BITS = 8 * MAX_BYTES;
  localparam int RX_W     = 8 * (MAX_BYTES - 1);
  localparam int CNT_W    = $clog2(MAX_BITS + 1);

  logic                go, run, tick, done;
  logic [CNT_W-1:0]    go_bits;
  logic [MAX_BITS-1:0] go_tx;
  logic [RX_W-1:0]     rx;

  spi_cmd_regs #(
    .ADDR_W(ADDR_W), .NPRG(NPRG), .RX_W(RX_W), .MAX_BITS(MAX_BITS),
    .CNT_W(CNT_W), .STRD_OP(STRD_OP), .STWR_OP(STWR_OP)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .go(go), .go_bits(go_bits), .go_tx(go_tx), .done(done), .done_rx(rx)
  );

  spi_cmd_sclk_gen #(.CLK_DIV(CLK_DIV)) u_div (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  spi_cmd_engine #(.MAX_BITS(MAX_BITS), .RX_W(RX_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst(rst), .go(go), .go_bits(go_bits), .go_tx(go_tx),
    .tick(tick), .miso(spi_miso), .run(run), .cs_n(spi_cs_n),
    .sck(spi_sck), .mosi(spi_mosi), .done(done), .rx(rx)
  );
endmodule

// File: rtl/spi_cmd_shifter_chk.sv
module spi_cmd_shifter_chk #(
  parameter int CLK_DIV  = 3,
  parameter int MAX_BITS = 56
) (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi
);
  logic [15:0] low_run;
  logic [7:0]  rise_cnt;
  logic        sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run  <= '0;
      rise_cnt <= '0;
      sck_d    <= 1'b0;
    end else begin
      sck_d <= spi_sck;
      if (spi_sck) low_run <= '0;
      else if (!spi_cs_n && low_run != 16'hFFFF) low_run <= low_run + 16'd1;
      if (spi_cs_n) rise_cnt <= '0;
      else if (spi_sck && !sck_d && rise_cnt != 8'hFF) rise_cnt <= rise_cnt + 8'd1;
    end
  end

  a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);
  a_r4_mosi_hold_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sck) |-> $stable(spi_mosi));
  a_r4_setup_after_select: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> !spi_sck);
  a_r5_release_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> (low_run == 16'(2 * CLK_DIV)));
  a_r3_bit_limit: assert property (@(posedge clk) disable iff (rst)
    rise_cnt <= 8'(MAX_BITS));
endmodule

bind spi_cmd_shifter spi_cmd_shifter_chk #(.CLK_DIV(CLK_DIV), .MAX_BITS(MAX_BITS)) u_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/tb_spi_cmd_shifter.sv
module tb_spi_cmd_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;
  localparam int B_CMD = 0, B_CNT = 1, B_STS = 2, B_PRG = 4, B_RB = 16;
  localparam logic [63:0] PAT = 64'hC3A5_5A3C_F00F_1296;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       spi_cs_n, spi_sck, spi_mosi;
  logic       spi_miso = 1'b0;

  spi_cmd_shifter #(.CLK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int n; logic [63:0] v; string tag; } xfer_t;
  xfer_t       sb_q[$];
  int          n_vec = 0, n_bad = 0, n_xfer = 0, exp_xfer = 0;
  logic [7:0]  sh_prg [6];
  logic [63:0] last_rx = '0;

  function automatic void check8(string tag, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endfunction

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic bus_write(input int widx, input logic [7:0] d);
    @(negedge clk);
    bus_addr = 8'(widx * 4); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int widx, output logic [7:0] d);
    @(negedge clk);
    bus_addr = 8'(widx * 4); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_prg(input int i, input logic [7:0] d);
    bus_write(B_PRG + i, d);
    sh_prg[i] = d;
  endtask

  function automatic logic [63:0] gen_vec();
    logic [63:0] v = '0;
    for (int i = 0; i < 6; i++) v[63 - 8*(5 - i) -: 8] = sh_prg[i];
    return v;
  endfunction

  function automatic logic [63:0] rx_of(int n);
    return (n == 0) ? 64'h0 : (PAT >> (64 - n));
  endfunction

  task automatic expect_bits(input int n, input logic [63:0] vec, input string tag);
    if (n > 0) begin
      sb_q.push_back('{n, vec >> (64 - n), tag});
      exp_xfer++;
    end
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] d = 8'hFF;
    for (int k = 0; k < 4000 && d != 8'h00; k++) bus_read(B_CMD, d);
    check8({tag, " R7 command self-clears"}, d, 8'h00);
  endtask

  task automatic check_rb(input logic [63:0] rxv, input string tag);
    logic [7:0] d;
    for (int i = 0; i < 6; i++) begin
      bus_read(B_RB + i, d);
      check8({tag, " R6 readback"}, d, rxv[8*i +: 8]);
    end
  endtask

  task automatic run_prog(input int cnt, input string tag);
    int n;
    logic [7:0] d;
    n = (cnt > 56) ? 56 : cnt;
    expect_bits(n, gen_vec(), tag);
    bus_write(B_CNT, 8'(cnt));
    bus_write(B_CMD, 8'h04);
    if (n > 0) begin
      bus_read(B_CMD, d);
      check8({tag, " R7 busy code"}, d, 8'h04);
    end
    wait_idle(tag);
    last_rx = rx_of(n);
    check_rb(last_rx, tag);
  endtask

  // flash model: drives the pattern MSB first, advancing on each falling clock
  initial begin
    forever begin
      @(negedge spi_cs_n);
      spi_miso = PAT[63];
      for (int mi = 1; mi < 64; mi++) begin
        @(negedge spi_sck or posedge spi_cs_n);
        if (spi_cs_n) break;
        spi_miso = PAT[63 - mi];
      end
    end
  end

  // monitor: collects MOSI bits per chip-select window and scores them
  initial begin
    logic [63:0] m_val = '0;
    int m_n = 0, gap = 0;
    logic sck_prev = 1'b0, cs_prev = 1'b1;
    xfer_t it;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (!spi_cs_n) begin
          if (spi_sck && !sck_prev) begin
            m_val = {m_val[62:0], spi_mosi};
            m_n++;
          end
          if (!spi_sck && sck_prev) gap = 1;
          else if (!spi_sck) gap++;
        end
        if (spi_cs_n && !cs_prev) begin
          n_xfer++;
          if (sb_q.size() == 0) begin
            n_vec++; n_bad++;
            $display("FAIL R10 unexpected transfer act=%0d bits exp=none", m_n);
          end else begin
            it = sb_q.pop_front();
            n_vec++;
            if (m_n != it.n || m_val != it.v) begin
              n_bad++;
              $display("FAIL %s R2 shifted bits act=%0d:%h exp=%0d:%h",
                       it.tag, m_n, m_val, it.n, it.v);
            end
            n_vec++;
            if (gap != 2 * DIV) begin
              n_bad++;
              $display("FAIL R5 release gap act=%0d exp=%0d", gap, 2 * DIV);
            end
          end
          m_val = '0; m_n = 0; gap = 0;
        end
        sck_prev = spi_sck;
        cs_prev  = spi_cs_n;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL R7 watchdog act=hung exp=done");
    finish_up();
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 6; i++) sh_prg[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    check8("R1 cs_n", {7'd0, spi_cs_n}, 8'h01);
    check8("R1 sck", {7'd0, spi_sck}, 8'h00);
    bus_read(B_CMD, d); check8("R1 cmd", d, 8'h00);
    bus_read(B_CNT, d); check8("R1 count", d, 8'h00);
    bus_read(B_STS, d); check8("R1 status", d, 8'h00);
    bus_read(B_PRG + 5, d); check8("R1 prog5", d, 8'h00);
    bus_read(B_RB, d); check8("R1 readback0", d, 8'h00);

    // R2: opcode only, three bytes returned
    set_prg(5, 8'h9F);
    run_prog(32, "R2 read-id");

    // R10 R11 R6: changes during a running transfer
    set_prg(5, 8'h02); set_prg(4, 8'h12); set_prg(3, 8'h34);
    set_prg(2, 8'h56); set_prg(1, 8'hA5); set_prg(0, 8'h00);
    expect_bits(40, gen_vec(), "R11 sampled");
    bus_write(B_CNT, 8'd40);
    bus_write(B_CMD, 8'h04);
    bus_read(B_RB, d); check8("R6 readback stable mid-transfer", d, last_rx[7:0]);
    bus_write(B_CNT, 8'd8);
    set_prg(4, 8'hFF);
    bus_write(B_CMD, 8'h02);
    bus_read(B_CMD, d); check8("R10 busy write ignored", d, 8'h04);
    wait_idle("R10");
    last_rx = rx_of(40);
    check_rb(last_rx, "R11");
    bus_read(B_CNT, d); check8("R11 count register holds new value", d, 8'd8);

    // R3 saturation at 56 bits
    for (int i = 0; i < 6; i++) set_prg(i, 8'(8'h31 + 8'(i * 17)));
    run_prog(80, "R3 saturate");

    // R2 R6 partial byte
    run_prog(12, "R2 odd count");

    // R3 zero count
    run_prog(0, "R3 zero count");
    @(negedge clk);
    check8("R3 no transfer for zero count", 8'(n_xfer), 8'(exp_xfer));

    // R8 status read leaves the readback bank alone
    run_prog(24, "R6 setup");
    bus_write(B_CNT, 8'd40);
    expect_bits(16, 64'h0500_0000_0000_0000, "R8 status read");
    bus_write(B_CMD, 8'h02);
    wait_idle("R8");
    bus_read(B_STS, d); check8("R8 status byte", d, PAT[55:48]);
    check_rb(last_rx, "R8");

    // R9 status write
    set_prg(5, 8'h5C);
    expect_bits(16, 64'h015C_0000_0000_0000, "R9 status write");
    bus_write(B_CMD, 8'h20);
    bus_read(B_CMD, d); check8("R9 busy code", d, 8'h20);
    wait_idle("R9");

    // R12 unknown code
    bus_write(B_CMD, 8'h08);
    bus_read(B_CMD, d); check8("R12 unknown code ignored", d, 8'h00);
    repeat (200) @(posedge clk);
    @(negedge clk);
    check8("R12 no transfer count", 8'(n_xfer), 8'(exp_xfer));
    check8("R10 scoreboard drained", 8'(sb_q.size()), 8'd0);
    finish_up();
  end
endmodule